// File: doc/BRIEF.md
# Interleaved Four-Bank Display Scan-Out Engine

This block produces the refresh reads for a 1024 by 768 pixel map of 24-bit RGB pixels. The map is striped over four banks, and a pixel lives in the bank given by its column modulo 4. Each bank holds one pixel per access, spread over three 8-bit colour lanes. The engine keeps horizontal and vertical position counters that count in four-pixel word slots. During the horizontal blanking before each visible line, it asks the memory side to load that line into the serial shift buffers. In each active slot it then shifts all four banks together and packs the returned lanes into one four-pixel output word, with the leftmost pixel first.

Blanking and sync lengths are parameters. Their defaults give a 1328 by 805 pixel frame, which at a pixel rate of 106.25 Mpixel/s refreshes at about 99.4 frames per second. The engine emits pixel words, a word-valid flag and the two sync flags, all aligned to one another. Analog conversion and memory-device timing lie outside the block.

Top module: `fb_scan_out`

## Requirements
- R1: While reset is asserted, and directly after it, `bank_shift`, `xfer_req`, `pix_valid`, `hsync` and `vsync` are 0 and `pix_word` is 0. The counters start at slot 0 of the last line of the frame, which is a blanking line.
- R2: Each active line gives exactly H_ACTIVE/4 consecutive valid words (256 with the defaults). Across a frame there are V_ACTIVE such lines.
- R3: In `pix_word`, pixel k (k = 0..3, column 4*slot+k, which comes from bank k) sits in bits [24k+23:24k]. Within a pixel, red is in bits [23:16], green in [15:8] and blue in [7:0]. In `bank_data`, lane c of bank b (c = 0 red, 1 green, 2 blue) sits in bits [(3b+c)*8+7:(3b+c)*8].
- R4: `xfer_req` pulses for one cycle in each line that is followed by an active line. The pulse comes in the first horizontal sync slot, and `xfer_row` carries the number of that following line. It never coincides with `bank_shift`.
- R5: Outside the active area, `pix_valid` is 0 and `pix_word` is 0.
- R6: `hsync` is high for H_SYNC/4 slots, starting H_FRONT/4 slots after the active part of the line. `vsync` is high for V_SYNC whole lines, starting V_FRONT lines after the last active line. Both are aligned with `pix_valid`.
- R7: `bank_shift` is high in exactly the active slots. The lane data is taken one cycle after the shift, and the packed word appears with `pix_valid` two cycles after the shift.
- R8: After the last line of the frame, the scan wraps to line 0. Row 0 is requested during the frame's final blanking line, and the next frame repeats the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bank_data | input | 96 | Serial outputs of the four banks, three 8-bit lanes each |
| bank_shift | output | 1 | Shift all bank serial buffers by one pixel |
| xfer_req | output | 1 | Row-transfer request pulse |
| xfer_row | output | 10 | Line number to load into the serial buffers |
| pix_valid | output | 1 | `pix_word` holds four visible pixels |
| pix_word | output | 96 | Four packed 24-bit pixels, leftmost in the low bits |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
`bank_shift`, `xfer_req` and `xfer_row` follow the position counters with no extra register, so they are due in the same cycle as the counter state. The bench's memory model returns lane data one cycle after it sees a shift. `pix_word`, `pix_valid` and both sync flags are due two cycles after the shift. The bench counts clock edges since reset release and maps that count to a frame position on its own. It compares the shift and transfer outputs against the current position and the pixel, valid and sync outputs against the position two edges earlier, always sampling at the falling edge.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam int unsigned COLOR_LANES = 3;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } scan_flags_t;
endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
  parameter int unsigned HA_W  = 256,
  parameter int unsigned HF_W  = 8,
  parameter int unsigned HS_W  = 32,
  parameter int unsigned HB_W  = 36,
  parameter int unsigned VA    = 768,
  parameter int unsigned VF    = 3,
  parameter int unsigned VS    = 6,
  parameter int unsigned VB    = 28,
  localparam int unsigned HT   = HA_W + HF_W + HS_W + HB_W,
  localparam int unsigned VT   = VA + VF + VS + VB,
  localparam int unsigned HW   = $clog2(HT),
  localparam int unsigned VW   = $clog2(VT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output fb_scan_pkg::scan_flags_t   flags,
  output logic                       fetch,
  output logic                       xfer,
  output logic [VW-1:0]              xfer_line
);
  localparam int unsigned HS_START = HA_W + HF_W;
  localparam int unsigned HS_END   = HS_START + HS_W;
  localparam int unsigned VS_START = VA + VF;
  localparam int unsigned VS_END   = VS_START + VS;

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          line_end;
  logic [VW-1:0] next_line;

  always_comb begin
    line_end  = (h_q == HW'(HT - 1));
    next_line = (v_q == VW'(VT - 1)) ? '0 : v_q + VW'(1);
    h_d       = line_end ? '0 : h_q + HW'(1);
    v_d       = line_end ? next_line : v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= VW'(VT - 1);
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  always_comb begin
    fetch     = (h_q < HW'(HA_W)) && (v_q < VW'(VA));
    flags.de  = fetch;
    flags.hs  = (h_q >= HW'(HS_START)) && (h_q < HW'(HS_END));
    flags.vs  = (v_q >= VW'(VS_START)) && (v_q < VW'(VS_END));
    xfer      = (h_q == HW'(HS_START)) && (next_line < VW'(VA));
    xfer_line = next_line;
  end
endmodule

// File: rtl/scan_delay.sv
module scan_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  fb_scan_pkg::scan_flags_t din,
  output fb_scan_pkg::scan_flags_t tap1,
  output fb_scan_pkg::scan_flags_t dout
);
  fb_scan_pkg::scan_flags_t pipe_q [DEPTH];
  fb_scan_pkg::scan_flags_t pipe_d [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb pipe_d[s] = din;
      end else begin : g_next
        always_comb pipe_d[s] = pipe_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_d[s];
      end
    end
  endgenerate

  assign tap1 = pipe_q[0];
  assign dout = pipe_q[DEPTH-1];
endmodule

// File: rtl/pixel_pack.sv
module pixel_pack #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = fb_scan_pkg::COLOR_LANES,
  localparam int unsigned PIX_W = LANES * LANE_W,
  localparam int unsigned WORD_W = BANKS * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] lanes,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] packed_w;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      for (genvar c = 0; c < LANES; c++) begin : g_lane
        assign packed_w[b*PIX_W + (LANES-1-c)*LANE_W +: LANE_W] =
               lanes[(b*LANES + c)*LANE_W +: LANE_W];
      end
    end
  endgenerate

  always_comb begin
    word_en = load || (word_q != '0);
    word_d  = load ? packed_w : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/fb_scan_out.sv
module fb_scan_out #(
  parameter int unsigned BANKS    = 4,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned H_ACTIVE = 1024,
  parameter int unsigned H_FRONT  = 32,
  parameter int unsigned H_SYNC   = 128,
  parameter int unsigned H_BACK   = 144,
  parameter int unsigned V_ACTIVE = 768,
  parameter int unsigned V_FRONT  = 3,
  parameter int unsigned V_SYNC   = 6,
  parameter int unsigned V_BACK   = 28,
  localparam int unsigned WORD_W  = BANKS * fb_scan_pkg::COLOR_LANES * LANE_W,
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int unsigned VW      = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bank_data,
  output logic              bank_shift,
  output logic              xfer_req,
  output logic [VW-1:0]     xfer_row,
  output logic              pix_valid,
  output logic [WORD_W-1:0] pix_word,
  output logic              hsync,
  output logic              vsync
);
  localparam int unsigned HA_W = H_ACTIVE / BANKS;
  localparam int unsigned HF_W = H_FRONT / BANKS;
  localparam int unsigned HS_W = H_SYNC / BANKS;
  localparam int unsigned HB_W = H_BACK / BANKS;
  localparam int unsigned LAT  = 2;

  fb_scan_pkg::scan_flags_t raw_flags, stage1, aligned;

  scan_timing #(
    .HA_W(HA_W), .HF_W(HF_W), .HS_W(HS_W), .HB_W(HB_W),
    .VA(V_ACTIVE), .VF(V_FRONT), .VS(V_SYNC), .VB(V_BACK)
  ) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (raw_flags),
    .fetch    (bank_shift),
    .xfer     (xfer_req),
    .xfer_line(xfer_row)
  );

  scan_delay #(.DEPTH(LAT)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_flags),
    .tap1 (stage1),
    .dout (aligned)
  );

  pixel_pack #(.BANKS(BANKS), .LANE_W(LANE_W)) u_pack (
    .clk  (clk),
    .rst_n(rst_n),
    .load (stage1.de),
    .lanes(bank_data),
    .word (pix_word)
  );

  assign pix_valid = aligned.de;
  assign hsync     = aligned.hs;
  assign vsync     = aligned.vs;
endmodule

// File: rtl/fb_scan_chk.sv
module fb_scan_chk #(
  parameter int unsigned HA_W   = 256,
  parameter int unsigned VA     = 768,
  parameter int unsigned VW     = 10,
  parameter int unsigned WORD_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_shift,
  input logic              xfer_req,
  input logic [VW-1:0]     xfer_row,
  input logic              pix_valid,
  input logic [WORD_W-1:0] pix_word,
  input logic              hsync,
  input logic              vsync
);
  localparam int unsigned RW = $clog2(HA_W + 1);
  logic [1:0]    warm_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      run_q  <= '0;
    end else begin
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      run_q <= pix_valid ? run_q + RW'(1) : '0;
    end
  end

  p_shift_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_shift |-> ##2 pix_valid);
  p_valid_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2 && pix_valid) |-> $past(bank_shift, 2));
  p_xfer_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !bank_shift);
  p_xfer_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> !xfer_req);
  p_xfer_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_row < VW'(VA)));
  p_sync_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |-> !pix_valid);
  p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (run_q < RW'(HA_W)));
  p_blank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_word == '0));
endmodule

bind fb_scan_out fb_scan_chk #(
  .HA_W(H_ACTIVE / BANKS), .VA(V_ACTIVE), .VW(VW), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_shift(bank_shift), .xfer_req(xfer_req),
  .xfer_row(xfer_row), .pix_valid(pix_valid), .pix_word(pix_word),
  .hsync(hsync), .vsync(vsync)
);

// File: tb/sim_fb_scan_out.sv
`timescale 1ns/1ps
module sim_fb_scan_out;
  localparam int HA = 32, HF = 8, HS = 12, HB = 12;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HAW = HA / 4, HT = (HA + HF + HS + HB) / 4;
  localparam int VT = VA + VF + VS + VB;
  localparam int VW = $clog2(VT);
  localparam int HSW0 = (HA + HF) / 4, HSW1 = (HA + HF + HS) / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [95:0] bank_data;
  logic        bank_shift, xfer_req, pix_valid, hsync, vsync;
  logic [VW-1:0] xfer_row;
  logic [95:0] pix_word;

  int tests = 0, fails = 0, tick = 0;
  int de_per_line [VT];

  fb_scan_out #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bank_data(bank_data), .bank_shift(bank_shift),
    .xfer_req(xfer_req), .xfer_row(xfer_row), .pix_valid(pix_valid),
    .pix_word(pix_word), .hsync(hsync), .vsync(vsync)
  );

  always #10 clk = ~clk;

  function automatic logic [23:0] pix_of(int x, int y);
    logic [7:0] xb, yb;
    xb = 8'(x); yb = 8'(y);
    return {yb + 8'h10, xb, xb ^ 8'hA5};
  endfunction

  // Memory model: a row transfer loads a line, each shift returns four pixels next cycle
  initial begin
    int row = 0, col = 0;
    logic s, x;
    logic [VW-1:0] r;
    bank_data = '0;
    forever begin
      @(negedge clk);
      s = bank_shift; x = xfer_req; r = xfer_row;
      @(posedge clk);
      #1;
      if (x) begin row = int'(r); col = 0; end
      if (s) begin
        for (int b = 0; b < 4; b++) begin
          logic [23:0] p;
          p = pix_of(col * 4 + b, row);
          bank_data[(b*3+0)*8 +: 8] = p[23:16];
          bank_data[(b*3+1)*8 +: 8] = p[15:8];
          bank_data[(b*3+2)*8 +: 8] = p[7:0];
        end
        col++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s tick %0d: actual %h expected %h", req, tick, act, exp);
    end
  endtask

  task automatic pos_of(int t, output int h, output int v);
    int p;
    p = ((VT - 1) * HT + t) % (HT * VT);
    h = p % HT; v = p / HT;
  endtask

  // One cycle: advance to the next falling edge and compare every output
  task automatic step(bit count_lines);
    int h, v, ho, vo, nl;
    logic [95:0] w;
    @(negedge clk);
    tick++;
    pos_of(tick, h, v);
    nl = (v + 1) % VT;
    check("R7 bank_shift", 96'(bank_shift), 96'(h < HAW && v < VA));
    check("R4 xfer_req", 96'(xfer_req), 96'(h == HSW0 && nl < VA));
    if (xfer_req) check("R4 xfer_row", 96'(xfer_row), 96'(nl));
    if (tick < 2) begin
      check("R1 pix_valid", 96'(pix_valid), 96'(0));
      check("R1 pix_word", pix_word, 96'(0));
    end else begin
      pos_of(tick - 2, ho, vo);
      w = '0;
      if (ho < HAW && vo < VA)
        for (int k = 0; k < 4; k++) w[k*24 +: 24] = pix_of(ho * 4 + k, vo);
      check("R5 pix_valid", 96'(pix_valid), 96'(ho < HAW && vo < VA));
      check("R3 pix_word", pix_word, w);
      check("R6 hsync", 96'(hsync), 96'(ho >= HSW0 && ho < HSW1));
      check("R6 vsync", 96'(vsync), 96'(vo >= VA + VF && vo < VA + VF + VS));
      if (count_lines && pix_valid) de_per_line[vo]++;
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 shift", 96'(bank_shift), 96'(0));
    check("R1 xfer", 96'(xfer_req), 96'(0));
    check("R1 valid", 96'(pix_valid), 96'(0));
    check("R1 word", pix_word, 96'(0));
    check("R1 sync", 96'({hsync, vsync}), 96'(0));
    rst_n = 1'b1;
    tick = 0;
  endtask

  task automatic t_first_frame();
    for (int i = 0; i < VT; i++) de_per_line[i] = 0;
    repeat (HT * VT) step(1'b1);
    for (int i = 0; i < VT; i++)
      check(i < VA ? "R2 words per line" : "R5 blank line words",
            96'(de_per_line[i]), 96'(i < VA ? HAW : 0));
  endtask

  task automatic t_frame_wrap();
    int xfers = 0;
    for (int i = 0; i < HT * VT + 4; i++) begin
      step(1'b0);
      if (xfer_req) xfers++;
    end
    check("R8 transfers per frame", 96'(xfers), 96'(VA));
  endtask

  task automatic t_reset_mid_line();
    repeat (5) step(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    check("R1 async shift", 96'(bank_shift), 96'(0));
    check("R1 async valid", 96'(pix_valid), 96'(0));
    check("R1 async word", pix_word, 96'(0));
    @(negedge clk);
    rst_n = 1'b1;
    tick = 0;
    repeat (HT * 2 + 6) step(1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_first_frame();
    t_frame_wrap();
    t_reset_mid_line();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule